// File: doc/BRIEF.md
# DMA Address Protection Cutoff Checker

This block sits beside the address path of a graphics DMA master. It holds one 32-bit protection control word and judges every address the master issues against it. For each request it decides whether the access may go ahead or must be blocked. Forwarding the access and answering it with an error are left to the surrounding fabric.

The control word has four fields. Three of them are cutoff counts. Each count protects a window that grows downward from a fixed region end, one step of a fixed size per count unit. The fourth field is a single bit that guards an AXI work-RAM window. The legacy main-memory count also guards the first step of the extended main-memory region whenever it is nonzero. A request is blocked if any active window covers it. The decision comes out one clock after the request, together with a valid strobe.

Top module: `dma_cutoff_guard`

## Requirements
- R1: After reset the control word reads 0. With a control word of 0 no address is ever blocked, and `chk_valid` stays low until the first request.
- R2: A write loads bits 10:0 of `cfg_wr_data` into the control word. Bits 31:11 of `cfg_rd_data` always read 0. The word holds its value in every cycle without a write.
- R3: Bits 3:0 are the legacy count L. When L > 0, addresses in [0x28000000 − L·0x800000, 0x28000000) are blocked.
- R4: The lowest step [0x20000000, 0x20800000) of the legacy region is never blocked by any setting.
- R5: Bits 7:4 are the extended count E. When E > 0, addresses in [0x30000000 − E·0x800000, 0x30000000) are blocked.
- R6: When L is nonzero, [0x28000000, 0x28800000) is blocked regardless of E.
- R7: Bits 10:9 are the scratch count S. When S > 0, addresses in [0x1F400000 − S·0x100000, 0x1F400000) are blocked.
- R8: Bit 8 set blocks the AXI work-RAM window [0x1FF80000, 0x20000000). Bit 8 clear leaves that window open.
- R9: The block flag is the OR of all windows, so several fields may be active at the same time. An address outside every window (below 0x1F000000 outside the AXI window, 0x1F400000 to 0x1FF7FFFF, or at or above 0x30000000) is never blocked.
- R10: A request in cycle n produces `chk_valid` = 1 and its block flag in cycle n+1. The decision uses the control word as it stood before any write in cycle n. With no request, `chk_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Current control word, upper bits zero |
| req_valid | input | 1 | DMA request address is valid |
| req_addr | input | ADDR_W | DMA request address |
| chk_valid | output | 1 | Decision strobe, one cycle after a request |
| chk_block | output | 1 | 1 = the request is blocked |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 8 MiB main-memory steps and 1 MiB scratch steps. It sweeps all 256 pairs of legacy and extended counts, probing the first and last byte of every step across both main-memory regions. It then sweeps all 2048 values of the 11-bit control word against the scratch step edges, the edges of the AXI work-RAM window and addresses outside every window. This makes every field combination and every window boundary visible at the ports. A write issued in the same cycle as a request confirms that the decision uses the control word from before the write.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int unsigned LEG_W = 4;
  localparam int unsigned EXT_W = 4;
  localparam int unsigned SCR_W = 2;
  localparam int unsigned CFG_W = LEG_W + EXT_W + 1 + SCR_W;

  // Field order is fixed by the control word layout (MSB first).
  typedef struct packed {
    logic [SCR_W-1:0] scr;
    logic             axi;
    logic [EXT_W-1:0] ext;
    logic [LEG_W-1:0] leg;
  } prot_cfg_t;
endpackage

// File: rtl/prot_ctrl_reg.sv
module prot_ctrl_reg
  import prot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output prot_cfg_t        cfg,
  output logic [31:0]      rd_data
);
  prot_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = prot_cfg_t'(wr_data[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg     = cfg_q;
  assign rd_data = {{(32-CFG_W){1'b0}}, cfg_q};

  assert_wr_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {{(32-CFG_W){1'b0}}, $past(wr_data[CFG_W-1:0])});
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/cutoff_window.sv
module cutoff_window #(
  parameter int unsigned          ADDR_W = 32,
  parameter int unsigned          CNT_W  = 4,
  parameter logic [ADDR_W-1:0]    REGION_END = '0,
  parameter logic [ADDR_W-1:0]    STEP = '0
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] lo;

  always_comb begin
    lo  = REGION_END - ({{(ADDR_W-CNT_W){1'b0}}, cnt} * STEP);
    hit = (cnt != '0) && (addr >= lo) && (addr < REGION_END);
  end
endmodule

// File: rtl/range_hit.sv
module range_hit #(
  parameter int unsigned       ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] SIZE = '0
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] off;

  always_comb begin
    off = addr - BASE;
    hit = en && (addr >= BASE) && (off < SIZE);
  end
endmodule

// File: rtl/dma_cutoff_guard.sv
module dma_cutoff_guard
  import prot_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] LEG_END   = 32'h2800_0000,
  parameter logic [ADDR_W-1:0] EXT_END   = 32'h3000_0000,
  parameter logic [ADDR_W-1:0] MAIN_STEP = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] SCR_END   = 32'h1F40_0000,
  parameter logic [ADDR_W-1:0] SCR_STEP  = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] AXI_BASE  = 32'h1FF8_0000,
  parameter logic [ADDR_W-1:0] AXI_SIZE  = 32'h0008_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wr_data,
  output logic [31:0]       cfg_rd_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              chk_valid,
  output logic              chk_block
);
  localparam logic [ADDR_W-1:0] EXT_BASE = LEG_END;
  localparam logic [ADDR_W-1:0] LEG_BASE = LEG_END - ADDR_W'(2**LEG_W) * MAIN_STEP;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  prot_cfg_t cfg;

  prot_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg     (cfg),
    .rd_data (cfg_rd_data)
  );

  logic leg_hit, ext_hit, scr_hit, guard_hit, axi_hit;

  cutoff_window #(.ADDR_W(ADDR_W), .CNT_W(LEG_W), .REGION_END(LEG_END), .STEP(MAIN_STEP))
    u_leg (.cnt(cfg.leg), .addr(req_addr), .hit(leg_hit));

  cutoff_window #(.ADDR_W(ADDR_W), .CNT_W(EXT_W), .REGION_END(EXT_END), .STEP(MAIN_STEP))
    u_ext (.cnt(cfg.ext), .addr(req_addr), .hit(ext_hit));

  cutoff_window #(.ADDR_W(ADDR_W), .CNT_W(SCR_W), .REGION_END(SCR_END), .STEP(SCR_STEP))
    u_scr (.cnt(cfg.scr), .addr(req_addr), .hit(scr_hit));

  range_hit #(.ADDR_W(ADDR_W), .BASE(EXT_BASE), .SIZE(MAIN_STEP))
    u_guard (.en(cfg.leg != '0), .addr(req_addr), .hit(guard_hit));

  range_hit #(.ADDR_W(ADDR_W), .BASE(AXI_BASE), .SIZE(AXI_SIZE))
    u_axi (.en(cfg.axi), .addr(req_addr), .hit(axi_hit));

  // Decision register: next-state and register processes kept apart.
  logic vld_d, vld_q, blk_d, blk_q;

  always_comb begin
    vld_d = req_valid;
    blk_d = req_valid & (leg_hit | ext_hit | scr_hit | guard_hit | axi_hit);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vld_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      blk_q <= blk_d;
    end
  end

  assign chk_valid = vld_q;
  assign chk_block = blk_q;

  assert_vld_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    req_valid |=> chk_valid);
  assert_idle_no_vld_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_valid |=> !chk_valid && !chk_block);
  assert_zero_cfg_open_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && cfg_rd_data == 32'd0) |=> !chk_block);
  assert_low_step_free_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_addr >= LEG_BASE && req_addr < LEG_BASE + MAIN_STEP) |=> !chk_block);
  assert_leg_bounds_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    leg_hit |-> (req_addr < LEG_END && cfg.leg != '0));
  assert_above_all_free_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_addr >= EXT_END) |=> !chk_block);
endmodule

// File: tb/dma_cutoff_guard_tb.sv
module dma_cutoff_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        chk_valid;
  logic        chk_block;

  int unsigned nvec = 0;
  int unsigned nfail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dma_cutoff_guard u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_addr(req_addr),
    .chk_valid(chk_valid), .chk_block(chk_block)
  );

  // Independent model: step indices over each region.
  function automatic bit model(input logic [10:0] c, input logic [31:0] a);
    int unsigned leg = c[3:0];
    int unsigned ext = c[7:4];
    int unsigned scr = c[10:9];
    bit r = 1'b0;
    if (a >= 32'h2000_0000 && a < 32'h3000_0000) begin
      int unsigned i = (a - 32'h2000_0000) >> 23;
      if (i < 16 && leg != 0 && i >= 16 - leg) r = 1'b1;
      if (i >= 16 && ext != 0 && i >= 32 - ext) r = 1'b1;
      if (i == 16 && leg != 0) r = 1'b1;
    end
    if (a >= 32'h1F00_0000 && a < 32'h1F40_0000) begin
      int unsigned j = (a - 32'h1F00_0000) >> 20;
      if (scr != 0 && j >= 4 - scr) r = 1'b1;
    end
    if (a >= 32'h1FF8_0000 && a < 32'h2000_0000 && c[8]) r = 1'b1;
    return r;
  endfunction

  function automatic string tag(input logic [31:0] a);
    if (a >= 32'h2000_0000 && a < 32'h2080_0000) return "R4";
    if (a >= 32'h2080_0000 && a < 32'h2800_0000) return "R3";
    if (a >= 32'h2800_0000 && a < 32'h2880_0000) return "R6";
    if (a >= 32'h2880_0000 && a < 32'h3000_0000) return "R5";
    if (a >= 32'h1F00_0000 && a < 32'h1F40_0000) return "R7";
    if (a >= 32'h1FF8_0000 && a < 32'h2000_0000) return "R8";
    return "R9";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic write_cfg(input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic probe(input logic [10:0] c, input logic [31:0] a, input string req);
    bit e;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    e = model(c, a);
    check(chk_valid === 1'b1 && chk_block === e, req, {30'd0, chk_valid, chk_block}, {30'd0, 1'b1, e});
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] sl [16];
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(cfg_rd_data === 32'd0, "R1", cfg_rd_data, 32'd0);
    check(chk_valid === 1'b0, "R1", {31'd0, chk_valid}, 32'd0);
    probe(11'd0, 32'h2700_0000, "R1");
    probe(11'd0, 32'h2F80_0000, "R1");
    probe(11'd0, 32'h1FF8_0000, "R1");
    // R10: idle cycle gives no strobe
    @(negedge clk);
    check(chk_valid === 1'b0, "R10", {31'd0, chk_valid}, 32'd0);

    // R2: readback masks upper bits, holds without a write
    write_cfg(32'hFFFF_FFFF);
    check(cfg_rd_data === 32'h0000_07FF, "R2", cfg_rd_data, 32'h7FF);
    @(negedge clk);
    check(cfg_rd_data === 32'h0000_07FF, "R2", cfg_rd_data, 32'h7FF);
    write_cfg(32'hA5A5_A52C);
    check(cfg_rd_data === 32'h0000_052C, "R2", cfg_rd_data, 32'h52C);

    // R3 R4 R5 R6: all legacy/extended count pairs, every step edge
    for (int l = 0; l < 16; l++) begin
      for (int x = 0; x < 16; x++) begin
        logic [10:0] c = {3'b000, x[3:0], l[3:0]};
        write_cfg({21'd0, c});
        for (int s = 0; s < 32; s++) begin
          logic [31:0] b = 32'h2000_0000 + s * 32'h0080_0000;
          probe(c, b, tag(b));
          probe(c, b + 32'h007F_FFFF, tag(b + 32'h007F_FFFF));
        end
      end
    end

    // R7 R8 R9: every control word against scratch/AXI edges and outside points
    sl[0]  = 32'h1F00_0000; sl[1]  = 32'h1F0F_FFFF; sl[2]  = 32'h1F10_0000; sl[3]  = 32'h1F1F_FFFF;
    sl[4]  = 32'h1F20_0000; sl[5]  = 32'h1F2F_FFFF; sl[6]  = 32'h1F30_0000; sl[7]  = 32'h1F3F_FFFF;
    sl[8]  = 32'h1F40_0000; sl[9]  = 32'h1EFF_FFFF; sl[10] = 32'h1FF7_FFFF; sl[11] = 32'h1FF8_0000;
    sl[12] = 32'h1FFF_FFFF; sl[13] = 32'h3000_0000; sl[14] = 32'hFFFF_FFFF; sl[15] = 32'h2880_0000;
    for (int v = 0; v < 2048; v++) begin
      logic [10:0] c = v[10:0];
      write_cfg({21'd0, c});
      for (int k = 0; k < 16; k++) probe(c, sl[k], tag(sl[k]));
      probe(c, 32'h0000_0000, "R9");
    end

    // R10: same-cycle write does not affect the decision of that request
    write_cfg(32'd0);
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h0000_000F;
    probe(11'd0, 32'h2700_0000, "R10");
    cfg_wr_en = 1'b0;
    probe(11'h00F, 32'h2700_0000, "R10");
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h0000_0000;
    probe(11'h00F, 32'h2080_0000, "R10");
    cfg_wr_en = 1'b0;
    probe(11'd0, 32'h2080_0000, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule